// File: doc/BRIEF.md
# Shadowed Real-Time Clock Register File

This block holds the host-visible register space of a real-time clock. It is 64 bytes, addressed over a simple synchronous bus. The low fourteen locations are clock registers, and the rest is plain scratch RAM. Eight of the clock registers hold the calendar and time of day in BCD. Each of these has an external copy that the host reads and writes. The block receives the matching internal values from the timekeeping counters, which live outside it. On each 100 Hz tick, all eight external copies are loaded from the internal values in the same cycle.

The host can freeze that transfer by clearing the transfer-enable bit in the command register. While frozen, it reads a coherent snapshot of the whole time set, or writes new time values without any of them being overwritten. The transfer also stops while the oscillator-disable control bit is set.

When the host sets transfer enable again after writing time values, the block pulses a load strobe for one cycle. The strobe carries the external copies back to the counters, and the periodic transfer is skipped during that cycle.

Top module: `rtc_shadow_regs`

## Requirements
- R1: Addresses 0x0E to 0x3F are scratch RAM and return the last value written. A read returns the addressed byte on `bus_rdata` in the cycle after `bus_rd`, and the value is held until the next read. A read and a write to the same address in the same cycle return the old value.
- R2: When `tick_100hz` is high, transfer enable is 1, the oscillator runs and no load pulse is present, all eight time copies load from `cnt_time_i` at that clock edge. Slot k of `cnt_time_i` (bits 8k+7:8k) maps to the addresses 0x0, 0x1, 0x2, 0x4, 0x6, 0x8, 0x9 and 0xA in that order.
- R3: Transfer enable is bit 7 of register 0x0B. While it is 0, the time copies change only by host writes.
- R4: Oscillator disable is bit 7 of register 0x09 and is active high. While it is 1, no transfer happens. `osc_run_o` is the inverse of that bit.
- R5: Eleven bits of the time registers are unused and always read 0. The readable masks are 0x0:FF, 0x1:7F, 0x2:7F, 0x4:7F, 0x6:07, 0x8:3F, 0x9:DF and 0xA:FF.
- R6: A write that changes transfer enable from 0 to 1, after at least one time register was written while frozen, raises `cnt_load_o` for exactly one cycle, starting in the next cycle. During that cycle `cnt_load_data_o` carries the external copies in slot order. A 0-to-1 write with no such time write raises no pulse.
- R7: Bits 7:6 of register 0x09 are host-owned control bits, and a transfer never changes them.
- R8: A host write and a transfer in the same cycle: the write wins for the addressed register, and the other time registers still load.
- R9: Reset clears every byte, `bus_rdata` and `cnt_load_o`. After reset, transfer is frozen and the oscillator runs.
- R10: Registers 0x03, 0x05, 0x07, 0x0B, 0x0C and 0x0D store all eight bits, and a transfer never changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| tick_100hz | input | 1 | Periodic transfer tick, one cycle wide |
| cnt_time_i | input | 64 | Internal time values, eight byte slots |
| cnt_load_o | output | 1 | One-cycle strobe to load the counters |
| cnt_load_data_o | output | 64 | External time copies, eight byte slots |
| osc_run_o | output | 1 | Oscillator enabled |

## Verification
The bound assertions check on every cycle that the time copies stay stable while frozen or while the oscillator is stopped with no host write. They also check that a qualified tick lands the seconds value, that the month control bits survive every cycle without a write, and that the load strobe is one cycle long and only occurs with transfer enable set. Other behaviours need the bench's scenarios to show: the RAM contents, the full per-address read masks, write-over-transfer precedence, and whether a load pulse occurs at all, which depends on the history of writes made while frozen. The bench runs those scenarios against a model computed from the requirements.

// File: rtl/rtc_shadow_regs.sv
`timescale 1ns/1ps
module rtc_shadow_regs #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              tick_100hz,
  input  logic [63:0]       cnt_time_i,
  output logic              cnt_load_o,
  output logic [63:0]       cnt_load_data_o,
  output logic              osc_run_o
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int N_SLOT  = 8;
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] MON_ADDR = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] SLOT_ADDR [N_SLOT] = '{
    ADDR_W'(0), ADDR_W'(1), ADDR_W'(2), ADDR_W'(4),
    ADDR_W'(6), ADDR_W'(8), ADDR_W'(9), ADDR_W'(10)};

  function automatic logic [7:0] rd_mask(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_W'(1), ADDR_W'(2), ADDR_W'(4): rd_mask = 8'h7F;
      ADDR_W'(6):                         rd_mask = 8'h07;
      ADDR_W'(8):                         rd_mask = 8'h3F;
      ADDR_W'(9):                         rd_mask = 8'hDF;
      default:                            rd_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] xfer_mask(input logic [ADDR_W-1:0] a);
    xfer_mask = (a == MON_ADDR) ? 8'h1F : rd_mask(a);
  endfunction

  function automatic logic is_time(input logic [ADDR_W-1:0] a);
    is_time = 1'b0;
    for (int k = 0; k < N_SLOT; k++)
      if (SLOT_ADDR[k] == a) is_time = 1'b1;
  endfunction

  logic [7:0] mem [DEPTH];
  logic       dirty;
  logic       te;
  logic       do_xfer;
  logic       load_set;

  assign te        = mem[CMD_ADDR][7];
  assign osc_run_o = ~mem[MON_ADDR][7];
  assign do_xfer   = tick_100hz & te & osc_run_o & ~cnt_load_o;
  assign load_set  = bus_wr & (bus_addr == CMD_ADDR) & bus_wdata[7] & ~te & dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_xfer)
        for (int k = 0; k < N_SLOT; k++)
          mem[SLOT_ADDR[k]] <= (mem[SLOT_ADDR[k]] & ~xfer_mask(SLOT_ADDR[k]))
                             | (cnt_time_i[k*8 +: 8] & xfer_mask(SLOT_ADDR[k]));
      if (bus_wr)
        mem[bus_addr] <= bus_wdata & rd_mask(bus_addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty      <= 1'b0;
      cnt_load_o <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      cnt_load_o <= load_set;
      if (load_set)
        dirty <= 1'b0;
      else if (bus_wr && is_time(bus_addr) && !te)
        dirty <= 1'b1;
      if (bus_rd)
        bus_rdata <= mem[bus_addr];
    end
  end

  for (genvar k = 0; k < N_SLOT; k++) begin : g_load
    assign cnt_load_data_o[k*8 +: 8] = mem[SLOT_ADDR[k]];
  end
endmodule

module rtc_shadow_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_rdata,
  input logic        tick_100hz,
  input logic [63:0] cnt_time_i,
  input logic        cnt_load_o,
  input logic [63:0] cnt_load_data_o,
  input logic        osc_run_o,
  input logic        te
);
  a_r2_seconds_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_100hz && te && osc_run_o && !cnt_load_o && !bus_wr)
      |=> cnt_load_data_o[15:8] == ($past(cnt_time_i[15:8]) & 8'h7F));
  a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !bus_wr) |=> $stable(cnt_load_data_o));
  a_r4_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run_o && !bus_wr) |=> $stable(cnt_load_data_o));
  a_r5_day_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 6'h06) |=> bus_rdata[7:3] == 5'd0);
  a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load_o |=> !cnt_load_o);
  a_r6_load_needs_te: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load_o |-> te);
  a_r7_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> cnt_load_data_o[55:54] == $past(cnt_load_data_o[55:54]));
endmodule

bind rtc_shadow_regs rtc_shadow_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tick_100hz(tick_100hz),
  .cnt_time_i(cnt_time_i), .cnt_load_o(cnt_load_o),
  .cnt_load_data_o(cnt_load_data_o), .osc_run_o(osc_run_o), .te(te));

// File: tb/rtc_shadow_regs_tb_top.sv
`timescale 1ns/1ps
module rtc_shadow_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        tick_100hz = 1'b0;
  logic [63:0] cnt_time_i = '0;
  logic        cnt_load_o;
  logic [63:0] cnt_load_data_o;
  logic        osc_run_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m [64];
  logic       m_dirty;
  logic       m_load;
  logic [7:0] m_rdata;
  localparam logic [5:0] SA [8] = '{6'h00, 6'h01, 6'h02, 6'h04, 6'h06, 6'h08, 6'h09, 6'h0A};

  always #4 clk = ~clk;

  rtc_shadow_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick_100hz(tick_100hz), .cnt_time_i(cnt_time_i), .cnt_load_o(cnt_load_o),
    .cnt_load_data_o(cnt_load_data_o), .osc_run_o(osc_run_o));

  function automatic logic [7:0] f_rmask(input logic [5:0] a);
    case (a)
      6'h01, 6'h02, 6'h04: return 8'h7F;
      6'h06: return 8'h07;
      6'h08: return 8'h3F;
      6'h09: return 8'hDF;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] f_xmask(input logic [5:0] a);
    return (a == 6'h09) ? 8'h1F : f_rmask(a);
  endfunction

  function automatic bit f_time(input logic [5:0] a);
    foreach (SA[k]) if (SA[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [63:0] f_ext();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = m[SA[k]];
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit wr, input bit rd, input logic [5:0] a,
                     input logic [7:0] d, input bit tk, input logic [63:0] ct);
    logic [7:0] nm [64];
    bit xfer, ld_next;
    string tag;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    tick_100hz = tk; cnt_time_i = ct;
    nm = m;
    xfer = tk && m[11][7] && !m[9][7] && !m_load;
    if (xfer)
      for (int k = 0; k < 8; k++)
        nm[SA[k]] = (m[SA[k]] & ~f_xmask(SA[k])) | (ct[k*8 +: 8] & f_xmask(SA[k]));
    if (wr) nm[a] = d & f_rmask(a);
    if (rd) m_rdata = m[a];
    ld_next = wr && a == 6'd11 && d[7] && !m[11][7] && m_dirty;
    if (ld_next) m_dirty = 1'b0;
    else if (wr && f_time(a) && !m[11][7]) m_dirty = 1'b1;
    @(posedge clk);
    #1;
    m = nm;
    m_load = ld_next;
    bus_wr = 1'b0; bus_rd = 1'b0; tick_100hz = 1'b0;
    if (rd) begin
      tag = (a >= 6'h0E) ? "R1 ram read" : f_time(a) ? "R5 time read" : "R10 ctrl read";
      chk(tag, bus_rdata, m_rdata);
    end
    chk("R6 load strobe", cnt_load_o, m_load);
    if (m_load) chk("R6 load data", cnt_load_data_o, f_ext());
    chk("R4 osc_run", osc_run_o, !m[9][7]);
  endtask

  task automatic wr_b(input logic [5:0] a, input logic [7:0] d);
    cyc(1, 0, a, d, 0, cnt_time_i);
  endtask

  task automatic rd_b(input logic [5:0] a);
    cyc(0, 1, a, 8'h00, 0, cnt_time_i);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ct;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 64; i++) m[i] = '0;
    m_dirty = 0; m_load = 0; m_rdata = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    chk("R9 reset rdata", bus_rdata, 8'h00);
    chk("R9 reset load", cnt_load_o, 1'b0);
    chk("R9 reset osc", osc_run_o, 1'b1);
    chk("R9 reset ext", cnt_load_data_o, 64'h0);

    // R3: frozen after reset, tick has no effect
    cyc(0, 0, 6'h00, 8'h00, 1, 64'h1122_3344_5566_7788);
    chk("R3 frozen ext", cnt_load_data_o, 64'h0);

    // R2: enable transfer, tick loads all slots
    wr_b(6'h0B, 8'h80);
    ct = 64'hA5C3_0F07_6B59_59FF;
    cyc(0, 0, 6'h00, 8'h00, 1, ct);
    chk("R2 xfer ext", cnt_load_data_o, f_ext());
    chk("R2 seconds", cnt_load_data_o[15:8], ct[15:8] & 8'h7F);

    // R5: unused bits
    wr_b(6'h06, 8'hFF); rd_b(6'h06);
    chk("R5 day mask", bus_rdata, 8'h07);
    wr_b(6'h08, 8'hFF); rd_b(6'h08);
    chk("R5 date mask", bus_rdata, 8'h3F);

    // R7: month control bits kept over transfer
    wr_b(6'h09, 8'h40);
    cyc(0, 0, 6'h00, 8'h00, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R7 month ctrl", cnt_load_data_o[55:48], 8'h5F);

    // R8: write wins over same-cycle transfer
    cyc(1, 0, 6'h02, 8'h33, 1, 64'h0101_0101_0101_0101);
    chk("R8 write wins", cnt_load_data_o[23:16], 8'h33);
    chk("R8 others load", cnt_load_data_o[15:8], 8'h01);

    // R10: control register untouched by transfer
    wr_b(6'h05, 8'hE7);
    cyc(0, 1, 6'h05, 8'h00, 1, 64'h0);
    chk("R10 alarm kept", bus_rdata, 8'hE7);

    // R4: stop oscillator
    wr_b(6'h09, 8'h80);
    chk("R4 osc stopped", osc_run_o, 1'b0);
    cyc(0, 0, 6'h00, 8'h00, 1, 64'h2222_2222_2222_2222);
    chk("R4 no xfer", cnt_load_data_o, f_ext());
    wr_b(6'h09, 8'h00);

    // R6: no pulse without frozen time write
    wr_b(6'h0B, 8'h00); wr_b(6'h0B, 8'h80);
    chk("R6 no pulse", cnt_load_o, 1'b0);
    // R6: pulse after frozen writes
    wr_b(6'h0B, 8'h00); wr_b(6'h01, 8'h45); wr_b(6'h04, 8'h12);
    cyc(1, 0, 6'h0B, 8'h80, 1, 64'h9999_9999_9999_9999);
    chk("R6 pulse", cnt_load_o, 1'b1);
    chk("R6 pulse data", cnt_load_data_o[15:8], 8'h45);
    cyc(0, 0, 6'h00, 8'h00, 1, 64'h0);
    chk("R6 xfer skipped in load cycle", cnt_load_data_o[31:24], 8'h12);
    chk("R6 single", cnt_load_o, 1'b0);

    // R1: RAM
    wr_b(6'h3F, 8'h5A); wr_b(6'h0E, 8'hC3);
    rd_b(6'h3F); chk("R1 ram top", bus_rdata, 8'h5A);
    rd_b(6'h0E); chk("R1 ram low", bus_rdata, 8'hC3);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] a;
      logic [7:0] d;
      bit w, r, t;
      a = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 3) == 0) a = 6'h0B;
      d = 8'($urandom);
      if (a == 6'h09 && $urandom_range(0, 3) != 0) d[7] = 1'b0;
      w = ($urandom_range(0, 2) == 0);
      r = ($urandom_range(0, 1) == 0);
      t = ($urandom_range(0, 5) == 0);
      cyc(w, r, a, d, t, {$urandom, $urandom});
      if (n % 50 == 0) chk("R2 R3 ext copies", cnt_load_data_o, f_ext());
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule